// File: doc/BRIEF.md
# Start-up and Auto-Restart Sequencer

This block sits on the control side of a resonant power converter. It decides when the power switches may run, and when the feedback node must be pulled up so that the switches stay off and the soft-start capacitor discharges. All timing is counted in cycles of a clock that runs at the converter's maximum switching frequency.

There are two hold-off lengths. The short one is applied each time the supply climbs back above its undervoltage lockout. The long one is applied after any of three events while the supply stays good: a fault request from the current-sense detector, an over/undervoltage pin trip, or a remote-off made by grounding that pin. When a hold-off count completes, the pull-up is released and switching starts at once.

A supply below lockout overrides every other input. Recovering from lockout always restarts through the short hold-off, even if a long hold-off was in progress when the supply dropped.

Top module: `restart_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the block is in the off state: `fb_pullup_en` is 1 and `sw_en` is 0.
- R2: When `supply_ok` is 0 at a clock edge, the block is in the off state after that edge (`fb_pullup_en` 1, `sw_en` 0), whatever state it was in and whatever the other inputs are.
- R3: When `supply_ok` is 1 at an edge in the off state, the block enters start-up hold and stays there for exactly SHORT_CYCLES cycles, then enters run.
- R4: In either hold state and in the off state, `fb_pullup_en` is 1 and `sw_en` is 0. In run, `fb_pullup_en` is 0 and `sw_en` is 1.
- R5: In run, a 1 on `cs_fault` at an edge moves the block into restart hold, which lasts exactly LONG_CYCLES cycles before run resumes.
- R6: In start-up hold, a fault (`cs_fault` 1 or `ovuv_ok` 0) moves the block into restart hold, which lasts LONG_CYCLES cycles.
- R7: In restart hold, a 1 on `cs_fault` at an edge restarts the count, so LONG_CYCLES further cycles pass from that edge before run resumes.
- R8: If `ovuv_ok` is 0 on the last cycle of restart hold, the block stays in restart hold for another full LONG_CYCLES period. A low `ovuv_ok` that ends before that last cycle does not change the hold length.
- R9: A supply drop during restart hold, followed by recovery, leads to the short start-up hold only, and not the long one.
- R10: `ovuv_ok` is active high. A 0 (pin trip or remote-off) at an edge during run starts a restart hold of LONG_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the maximum switching frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | 1 when the supply is above undervoltage lockout |
| cs_fault | input | 1 | Fault request from the current-sense detector, active high |
| ovuv_ok | input | 1 | Over/undervoltage pin status, 1 = normal, 0 = tripped or remote-off |
| fb_pullup_en | output | 1 | Enables the feedback pull-up: switches held off, soft-start discharged |
| sw_en | output | 1 | Power switching enabled |

## Verification
The bench measures each hold-off exactly, in cycles from the triggering edge to the first cycle of run. A counter compared one value off would show up as a hold that is one cycle short or long. The bench repeats a current-sense fault in the middle of a restart hold, and a design that ignored it would resume run too early. It keeps the over/undervoltage pin low across the end of a restart hold, where a design that rechecked the pin too early or not at all would give a hold of the wrong length. It also drops and recovers the supply during a long hold: a design that kept the long hold in mind across lockout would hold far longer than the short period.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_STARTUP = 2'd1,
    ST_RUN     = 2'd2,
    ST_RESTART = 2'd3
  } seq_state_e;

  // Last count value of a hold lasting len cycles (count starts at zero)
  function automatic int unsigned hold_last(input int unsigned len);
    return len - 1;
  endfunction

  // Counter width able to reach hold_last(len)
  function automatic int unsigned cnt_bits(input int unsigned len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/rs_hold_timer.sv
module rs_hold_timer #(
  parameter int unsigned SHORT_CYCLES = 1024,
  parameter int unsigned LONG_CYCLES  = 131072,
  localparam int unsigned CW = rs_pkg::cnt_bits(LONG_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          short_done,
  output logic          long_done
);
  localparam logic [CW-1:0] SHORT_LAST = CW'(rs_pkg::hold_last(SHORT_CYCLES));
  localparam logic [CW-1:0] LONG_LAST  = CW'(rs_pkg::hold_last(LONG_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign short_done = (cnt == SHORT_LAST);
  assign long_done  = (cnt == LONG_LAST);

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/rs_state_ctrl.sv
module rs_state_ctrl
  import rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_fault,
  input  logic       ovuv_ok,
  input  logic       short_done,
  input  logic       long_done,
  output seq_state_e state_q,
  output logic       timer_clr
);
  seq_state_e state_d;
  logic       fault_any;
  logic       restart_now;

  assign fault_any = cs_fault || !ovuv_ok;

  always_comb begin
    state_d     = state_q;
    restart_now = 1'b0;
    if (!supply_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = ST_STARTUP;
        ST_STARTUP: begin
          if (fault_any)       state_d = ST_RESTART;
          else if (short_done) state_d = ST_RUN;
        end
        ST_RUN:     if (fault_any) state_d = ST_RESTART;
        ST_RESTART: begin
          if (cs_fault) restart_now = 1'b1;
          else if (long_done) begin
            if (!ovuv_ok) restart_now = 1'b1;
            else          state_d     = ST_RUN;
          end
        end
        default:    state_d = ST_OFF;
      endcase
    end
  end

  assign timer_clr = (state_d != state_q) || restart_now ||
                     (state_q == ST_OFF) || (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  // R2
  supply_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_q == ST_OFF);
  // R3
  off_to_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && supply_ok) |=> state_q == ST_STARTUP);
  // R5
  run_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && supply_ok && cs_fault) |=> state_q == ST_RESTART);
  // R8
  ovuv_rehold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESTART && supply_ok && long_done && !ovuv_ok)
      |=> state_q == ST_RESTART);
endmodule

// File: rtl/restart_sequencer.sv
module restart_sequencer
  import rs_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 1024,
  parameter int unsigned LONG_CYCLES  = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic cs_fault,
  input  logic ovuv_ok,
  output logic fb_pullup_en,
  output logic sw_en
);
  localparam int unsigned CW = cnt_bits(LONG_CYCLES);

  seq_state_e    state_q;
  logic          timer_clr;
  logic [CW-1:0] hold_cnt;
  logic          short_done;
  logic          long_done;

  rs_hold_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (timer_clr),
    .cnt       (hold_cnt),
    .short_done(short_done),
    .long_done (long_done)
  );

  rs_state_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cs_fault  (cs_fault),
    .ovuv_ok   (ovuv_ok),
    .short_done(short_done),
    .long_done (long_done),
    .state_q   (state_q),
    .timer_clr (timer_clr)
  );

  assign sw_en        = (state_q == ST_RUN);
  assign fb_pullup_en = !sw_en;

  // R3
  startup_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STARTUP) |-> hold_cnt <= CW'(hold_last(SHORT_CYCLES)));
  // R5
  restart_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESTART) |-> hold_cnt <= CW'(hold_last(LONG_CYCLES)));
  // R4
  run_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(short_done || long_done));
endmodule

// File: tb/restart_sequencer_tb.sv
`timescale 1ns/1ps
module restart_sequencer_tb;
  localparam int SHORT = 8;
  localparam int LONG  = 32;
  localparam int M_OFF = 0, M_SU = 1, M_RUN = 2, M_RH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic cs_fault = 1'b0;
  logic ovuv_ok = 1'b1;
  logic fb_pullup_en, sw_en;

  int n_chk = 0;
  int n_fail = 0;
  int m_st = M_OFF;
  int m_cnt = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  restart_sequencer #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_fault(cs_fault),
    .ovuv_ok(ovuv_ok), .fb_pullup_en(fb_pullup_en), .sw_en(sw_en));

  // Behavioural reference: one state number and one cycle tally
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_OFF; m_cnt = 0;
    end else if (!supply_ok) begin
      m_st = M_OFF; m_cnt = 0;
    end else if (m_st == M_OFF) begin
      m_st = M_SU; m_cnt = 0;
    end else if (m_st == M_SU) begin
      if (cs_fault || !ovuv_ok) begin m_st = M_RH; m_cnt = 0; end
      else if (m_cnt + 1 == SHORT) begin m_st = M_RUN; m_cnt = 0; end
      else m_cnt++;
    end else if (m_st == M_RUN) begin
      if (cs_fault || !ovuv_ok) begin m_st = M_RH; m_cnt = 0; end
    end else begin
      if (cs_fault) m_cnt = 0;
      else if (m_cnt + 1 == LONG) begin
        if (ovuv_ok) m_st = M_RUN;
        m_cnt = 0;
      end else m_cnt++;
    end
  end

  task automatic check(input string t, input logic act_pu, input logic act_sw,
                       input logic exp_pu, input logic exp_sw);
    n_chk++;
    if (act_pu !== exp_pu || act_sw !== exp_sw) begin
      n_fail++;
      $display("FAIL %s: pullup/sw actual %b%b expected %b%b", t, act_pu, act_sw, exp_pu, exp_sw);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tag, fb_pullup_en, sw_en, (m_st != M_RUN), (m_st == M_RUN));
  endtask

  // Count low cycles of sw_en until run; release faults after rel_at steps
  task automatic measure_low(input int exp_n, input string t, input int rel_at);
    int n = 0;
    int s = 0;
    tag = t;
    while (n <= exp_n + 10) begin
      step();
      s++;
      if (s == rel_at) begin cs_fault = 1'b0; ovuv_ok = 1'b1; end
      if (sw_en === 1'b1) break;
      check("R4", fb_pullup_en, sw_en, 1'b1, 1'b0);
      n++;
    end
    n_chk++;
    if (n != exp_n) begin
      n_fail++;
      $display("FAIL %s: hold length actual %0d expected %0d", t, n, exp_n);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", fb_pullup_en, sw_en, 1'b1, 1'b0);
    rst_n = 1'b1;
    tag = "R2";
    repeat (3) step();
    check("R1", fb_pullup_en, sw_en, 1'b1, 1'b0);

    // R3 power-up short hold
    supply_ok = 1'b1;
    measure_low(SHORT, "R3", 0);
    tag = "R4";
    repeat (5) step();
    check("R4", fb_pullup_en, sw_en, 1'b0, 1'b1);

    // R5 current-sense fault in run
    cs_fault = 1'b1;
    measure_low(LONG, "R5", 1);
    repeat (3) step();

    // R10 pin trip / remote-off in run
    ovuv_ok = 1'b0;
    measure_low(LONG, "R10", 1);
    repeat (3) step();

    // R7 repeated current-sense fault inside restart hold
    tag = "R7";
    cs_fault = 1'b1; step(); cs_fault = 1'b0;
    repeat (9) step();
    cs_fault = 1'b1; step(); cs_fault = 1'b0;
    measure_low(LONG - 1, "R7", 0);
    repeat (3) step();

    // R8 pin still low at the end of the hold gives a second period
    ovuv_ok = 1'b0;
    measure_low(2 * LONG, "R8", LONG + 3);
    repeat (3) step();

    // R8 pin dip confined to the middle of the hold has no effect
    tag = "R8";
    cs_fault = 1'b1; step(); cs_fault = 1'b0;
    repeat (4) step();
    ovuv_ok = 1'b0; repeat (3) step(); ovuv_ok = 1'b1;
    measure_low(LONG - 8, "R8", 0);
    repeat (3) step();

    // R2 supply loss from run
    supply_ok = 1'b0;
    step();
    check("R2", fb_pullup_en, sw_en, 1'b1, 1'b0);
    cs_fault = 1'b1; ovuv_ok = 1'b0;
    step();
    check("R2", fb_pullup_en, sw_en, 1'b1, 1'b0);
    cs_fault = 1'b0; ovuv_ok = 1'b1;

    // R6 fault during start-up hold
    supply_ok = 1'b1;
    tag = "R6";
    repeat (3) step();
    cs_fault = 1'b1;
    measure_low(LONG, "R6", 1);
    repeat (3) step();

    // R6 pin trip during start-up hold
    supply_ok = 1'b0; step(); supply_ok = 1'b1;
    repeat (2) step();
    ovuv_ok = 1'b0;
    measure_low(LONG, "R6", 1);
    repeat (3) step();

    // R9 lockout during restart hold returns through the short hold
    tag = "R9";
    cs_fault = 1'b1; step(); cs_fault = 1'b0;
    repeat (5) step();
    supply_ok = 1'b0; step(); supply_ok = 1'b1;
    measure_low(SHORT, "R9", 0);
    repeat (4) step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule